// File: doc/BRIEF.md
# Erased Page Bit-Flip Detector

This block follows a hardware-ECC page read from NAND flash. It decides whether a page that the decoder flagged as uncorrectable is really a blank (erased) page on which a few bits have flipped from 1 to 0. When the start pulse arrives, the block looks at the decoder's status byte. If that byte reports success, the block passes the corrected-bit count straight to its outputs. If it reports failure, the block takes the page image as a stream of 32-bit words. The stream holds the main area first (2048 bytes, 512 words) and then the spare area (64 bytes, 16 words). The block counts the 0 bits in that stream.

The zero-bit budget is half the ECC strength. Strength select 0 means strength 24, so the budget is 12. Strength select 1 means strength 32, so the budget is 16. Once the running total passes the budget, the block stops counting. It still accepts and discards the rest of the stream, so the producer never stalls or falls out of step. When the last word is taken, the block gives its verdict. An uncorrectable page raises `fail_o`. An erased page raises `erased_o`, and the buffer owner then overwrites the page with 0xFF.

Top module: `erased_page_checker`

## Requirements
- R1: When `start_i` arrives while idle and bit 7 of `ecc_status_i` is 0, `done_o` pulses on the next cycle. `flips_o` equals bits 5:0 of the status byte, `fail_o` and `erased_o` are 0, and `word_ready_o` stays low.
- R2: When `start_i` arrives while idle and status bit 7 is 1, `word_ready_o` rises on the next cycle. It stays high until exactly 528 words (512 main, then 16 spare) have been accepted. While idle, `word_ready_o` is low.
- R3: Each accepted word adds the number of 0 bits among its 32 bits to a running total. The total spans both areas.
- R4: The budget is 12 when `strength_hi_i` is 0 and 16 when it is 1. It is sampled on the cycle the scan starts.
- R5: At the end of a scan, a total at or below the budget gives `erased_o`=1, `fail_o`=0 and `flips_o` equal to the total. A total above the budget gives `fail_o`=1 and `erased_o`=0.
- R6: Once the total exceeds the budget, later words add nothing. They are still accepted, and `flips_o` reports the total at the point counting stopped.
- R7: `done_o` is high for one cycle. It rises right after the edge that accepts the 528th word. The verdict then holds until the next start, and `fail_o` and `erased_o` are never both 1.
- R8: A `start_i` pulse during a scan is ignored and does not disturb the scan in progress.
- R9: After reset, `done_o`, `fail_o` and `erased_o` are 0, `flips_o` is 0 and `word_ready_o` is 0.
- R10: A word is counted only on a cycle with both `word_valid_i` and `word_ready_o` high. Gaps in `word_valid_i` do not alter the result.
- R11: Starting a scan clears `fail_o`, `erased_o` and `flips_o` to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to evaluate a page |
| ecc_status_i | input | 8 | Decoder status: bit 7 uncorrectable, bits 5:0 corrected count |
| strength_hi_i | input | 1 | 0: strength 24 (budget 12), 1: strength 32 (budget 16) |
| word_valid_i | input | 1 | Page word offered |
| word_data_i | input | 32 | Page word, main area first then spare |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| done_o | output | 1 | One-cycle verdict strobe |
| fail_o | output | 1 | Page is uncorrectable |
| erased_o | output | 1 | Page is erased; owner fills it with 0xFF |
| flips_o | output | 7 | Corrected-bit count or zero-bit total |

## Verification
The bench targets totals that land exactly on the budget and one bit past it, for both strength settings. A design that compares with the wrong sign or uses the other budget would flip the verdict in exactly these cases. One page puts heavy damage in the main area and more zeros in the spare area; a detector that does not stop early would report the larger sum. Other runs insert idle gaps in the word stream and send a stray start in the middle of a scan. A design that counts unhandshaked words, or that restarts on the stray pulse, would lose the word alignment and report at the wrong cycle. A status byte with bit 6 set but bit 7 clear checks that only bit 7 chooses the scan.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int WORD_W        = 32;
  localparam int SUM_W         = 7;
  localparam int STRENGTH_LO   = 24;
  localparam int STRENGTH_HI   = 32;
  localparam int ZC_W          = $clog2(WORD_W + 1);
  localparam int STAT_FAIL_BIT = 7;
  localparam int STAT_CNT_W    = 6;

  typedef enum logic {PH_IDLE = 1'b0, PH_SCAN = 1'b1} phase_e;

  // number of cleared bits in one word
  function automatic logic [ZC_W-1:0] zeros_in_word(input logic [WORD_W-1:0] w);
    logic [ZC_W-1:0] n;
    n = '0;
    for (int b = 0; b < WORD_W; b++) n = n + ZC_W'(~w[b]);
    return n;
  endfunction

  // add with clamp at the all-ones value
  function automatic logic [SUM_W-1:0] sat_add(input logic [SUM_W-1:0] a,
                                               input logic [ZC_W-1:0] b);
    logic [SUM_W:0] s;
    s = {1'b0, a} + (SUM_W+1)'(b);
    return s[SUM_W] ? '1 : s[SUM_W-1:0];
  endfunction

  // half the selected correction strength
  function automatic logic [SUM_W-1:0] flip_limit(input logic hi);
    return hi ? SUM_W'(STRENGTH_HI / 2) : SUM_W'(STRENGTH_LO / 2);
  endfunction
endpackage

// File: rtl/esd_zero_accum.sv
module esd_zero_accum
  import esd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SUM_W-1:0]  limit_i,
  output logic [SUM_W-1:0]  total_o,
  output logic              over_o,
  output logic [SUM_W-1:0]  sum_next_o,
  output logic              over_next_o
);
  logic [SUM_W-1:0] total_q;

  assign total_o     = total_q;
  assign over_o      = total_q > limit_i;
  assign sum_next_o  = over_o ? total_q : sat_add(total_q, zeros_in_word(word_i));
  assign over_next_o = sum_next_o > limit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       total_q <= '0;
    else if (clear_i) total_q <= '0;
    else if (add_i)   total_q <= sum_next_o;
  end
endmodule

// File: rtl/esd_word_seq.sv
module esd_word_seq #(
  parameter int DATA_WORDS  = 512,
  parameter int SPARE_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  output logic last_o
);
  localparam int TOTAL_WORDS = DATA_WORDS + SPARE_WORDS;
  localparam int IDX_W       = $clog2(TOTAL_WORDS);

  logic [IDX_W-1:0] idx_q;

  assign last_o = idx_q == IDX_W'(TOTAL_WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (load_i) idx_q <= '0;
    else if (step_i) idx_q <= last_o ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/erased_page_checker.sv
module erased_page_checker
  import esd_pkg::*;
#(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        ecc_status_i,
  input  logic              strength_hi_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              erased_o,
  output logic [SUM_W-1:0]  flips_o
);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int DATA_WORDS  = DATA_BYTES / WORD_BYTES;
  localparam int SPARE_WORDS = SPARE_BYTES / WORD_BYTES;

  phase_e           phase_q;
  logic [SUM_W-1:0] limit_q;
  logic             done_q, fail_q, erased_q;
  logic [SUM_W-1:0] flips_q;

  // named internal events
  logic             busy, quick_go, scan_go, accept, finish, stopped;
  logic [SUM_W-1:0] acc_total, acc_next;
  logic             acc_next_over;

  assign busy     = phase_q == PH_SCAN;
  assign quick_go = !busy && start_i && !ecc_status_i[STAT_FAIL_BIT];
  assign scan_go  = !busy && start_i &&  ecc_status_i[STAT_FAIL_BIT];
  assign accept   = busy && word_valid_i;

  esd_zero_accum u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (scan_go),
    .add_i       (accept),
    .word_i      (word_data_i),
    .limit_i     (limit_q),
    .total_o     (acc_total),
    .over_o      (stopped),
    .sum_next_o  (acc_next),
    .over_next_o (acc_next_over)
  );

  logic seq_last;
  esd_word_seq #(
    .DATA_WORDS  (DATA_WORDS),
    .SPARE_WORDS (SPARE_WORDS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (scan_go),
    .step_i (accept),
    .last_o (seq_last)
  );

  assign finish = accept && seq_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      limit_q  <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      erased_q <= 1'b0;
      flips_q  <= '0;
    end else begin
      done_q <= quick_go || finish;
      if (quick_go) begin
        fail_q   <= 1'b0;
        erased_q <= 1'b0;
        flips_q  <= SUM_W'(ecc_status_i[STAT_CNT_W-1:0]);
      end else if (scan_go) begin
        phase_q  <= PH_SCAN;
        limit_q  <= flip_limit(strength_hi_i);
        fail_q   <= 1'b0;
        erased_q <= 1'b0;
        flips_q  <= '0;
      end else if (finish) begin
        phase_q  <= PH_IDLE;
        fail_q   <= acc_next_over;
        erased_q <= !acc_next_over;
        flips_q  <= acc_next;
      end
    end
  end

  assign word_ready_o = busy;
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign erased_o     = erased_q;
  assign flips_o      = flips_q;
endmodule

// File: rtl/esd_checker.sv
module esd_checker
  import esd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [7:0]       ecc_status_i,
  input logic             word_ready_o,
  input logic             done_o,
  input logic             fail_o,
  input logic             erased_o,
  input logic [SUM_W-1:0] flips_o,
  input logic             busy,
  input logic             quick_go,
  input logic             scan_go,
  input logic             accept,
  input logic             finish,
  input logic             stopped,
  input logic [SUM_W-1:0] acc_total,
  input logic [SUM_W-1:0] limit_q
);
  a_r1_quick_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    quick_go |=> done_o && !fail_o && !erased_o && !word_ready_o &&
                 flips_o == SUM_W'($past(ecc_status_i[5:0])));

  a_r2_scan_opens: assert property (@(posedge clk) disable iff (!rst_n)
    scan_go |=> word_ready_o);

  a_r5_erased_within: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && erased_o |-> flips_o <= limit_q);

  a_r5_fail_beyond: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> flips_o > limit_q);

  a_r6_frozen_total: assert property (@(posedge clk) disable iff (!rst_n)
    accept && stopped |=> $stable(acc_total));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_o && erased_o));

  a_r7_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !word_ready_o);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_i && !finish |=> word_ready_o && !done_o);

  a_r11_scan_clears: assert property (@(posedge clk) disable iff (!rst_n)
    scan_go |=> !done_o && !fail_o && !erased_o && flips_o == '0);
endmodule

bind erased_page_checker esd_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ecc_status_i (ecc_status_i),
  .word_ready_o (word_ready_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .erased_o     (erased_o),
  .flips_o      (flips_o),
  .busy         (busy),
  .quick_go     (quick_go),
  .scan_go      (scan_go),
  .accept       (accept),
  .finish       (finish),
  .stopped      (stopped),
  .acc_total    (acc_total),
  .limit_q      (limit_q)
);

// File: tb/test_erased_page_checker.sv
module test_erased_page_checker;
  localparam int NWORDS = 528;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  ecc_status_i = 8'h00;
  logic        strength_hi_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = 32'hFFFF_FFFF;
  logic        word_ready_o, done_o, fail_o, erased_o;
  logic [6:0]  flips_o;

  int errors = 0;
  int checks = 0;
  bit compare_on = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  erased_page_checker i_erased_page_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ecc_status_i(ecc_status_i),
    .strength_hi_i(strength_hi_i), .word_valid_i(word_valid_i),
    .word_data_i(word_data_i), .word_ready_o(word_ready_o), .done_o(done_o),
    .fail_o(fail_o), .erased_o(erased_o), .flips_o(flips_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_fail, m_erased;
  int m_idx, m_total, m_limit, m_count;

  function automatic int zero_count(input logic [31:0] w);
    int n = 0;
    for (int b = 0; b < 32; b++) if (w[b] == 1'b0) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fail = 0; m_erased = 0;
      m_idx = 0; m_total = 0; m_limit = 0; m_count = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i && !ecc_status_i[7]) begin
          m_done = 1; m_fail = 0; m_erased = 0; m_count = ecc_status_i & 8'h3F;
        end else if (start_i) begin
          m_busy = 1; m_idx = 0; m_total = 0; m_fail = 0; m_erased = 0; m_count = 0;
          m_limit = strength_hi_i ? 16 : 12;
        end
      end else if (word_valid_i) begin
        if (m_total <= m_limit) begin
          m_total = m_total + zero_count(word_data_i);
          if (m_total > 127) m_total = 127;
        end
        if (m_idx == NWORDS - 1) begin
          m_busy = 0; m_done = 1;
          m_fail = m_total > m_limit; m_erased = !m_fail; m_count = m_total;
        end else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      check("R7 done", done_o, m_done);
      check("R5 fail", fail_o, m_fail);
      check("R5 erased", erased_o, m_erased);
      check("R3 flips", flips_o, m_count);
      check("R2 ready", word_ready_o, m_busy);
    end
  end

  function automatic logic [31:0] page_word(input int idx, input int zd, input int zs);
    logic [63:0] m;
    if (idx == 5)        m = (64'd1 << zd) - 1;
    else if (idx == 520) m = (64'd1 << zs) - 1;
    else                 m = 64'd0;
    return ~m[31:0];
  endfunction

  task automatic quick(input logic [7:0] st, input int exp_cnt);
    start_i = 1; ecc_status_i = st;
    @(negedge clk);
    start_i = 0;
    check("R1 done", done_o, 1);
    check("R1 count", flips_o, exp_cnt);
    check("R1 no verdict", fail_o | erased_o, 0);
    check("R1 ready low", word_ready_o, 0);
    @(negedge clk);
  endtask

  task automatic scan(input logic sel, input int zd, input int zs, input bit gaps,
                      input int mid_start, input int exp_fail, input int exp_cnt,
                      input string req);
    int cyc = 0;
    int idx = 0;
    start_i = 1; ecc_status_i = 8'hA5; strength_hi_i = sel;
    @(negedge clk);
    start_i = 0;
    check("R11 cleared", {28'd0, fail_o, erased_o, done_o} + int'(flips_o), 0);
    check("R2 ready rises", word_ready_o, 1);
    strength_hi_i = !sel;  // R4: sampled only at start
    while (idx < NWORDS) begin
      word_valid_i = gaps ? (cyc % 3 != 1) : 1'b1;
      word_data_i  = word_valid_i ? page_word(idx, zd, zs) : 32'h0;
      start_i      = (idx == mid_start) && word_valid_i;
      ecc_status_i = start_i ? 8'h05 : 8'hA5;
      @(negedge clk);
      if (start_i) check("R8 still scanning", word_ready_o, 1);
      start_i = 0;
      if (word_valid_i) idx++;
      cyc++;
    end
    word_valid_i = 0; word_data_i = 32'hFFFF_FFFF;
    check({req, " done"}, done_o, 1);
    check({req, " fail"}, fail_o, exp_fail);
    check({req, " erased"}, erased_o, 1 - exp_fail);
    check({req, " flips"}, flips_o, exp_cnt);
    @(negedge clk);
    check("R7 pulse ends", done_o, 0);
    check("R7 verdict held", flips_o, exp_cnt);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 done", done_o, 0);
    check("R9 verdict", fail_o | erased_o, 0);
    check("R9 flips", flips_o, 0);
    check("R9 ready", word_ready_o, 0);
    compare_on = 1;
    // R10: words offered while idle are not taken
    word_valid_i = 1; word_data_i = 32'h0;
    repeat (3) begin @(negedge clk); check("R10 idle ready", word_ready_o, 0); end
    word_valid_i = 0; word_data_i = 32'hFFFF_FFFF;
    quick(8'h2A, 42);                            // R1
    quick(8'h7F, 63);                            // R1: bit 6 does not start a scan
    scan(1'b0, 0, 0, 0, -1, 0, 0, "R3 clean");
    scan(1'b0, 7, 5, 0, -1, 0, 12, "R4 at budget 12");
    scan(1'b0, 8, 5, 0, -1, 1, 13, "R5 over budget 12");
    scan(1'b1, 10, 6, 0, -1, 0, 16, "R4 at budget 16");
    scan(1'b1, 11, 6, 0, -1, 1, 17, "R5 over budget 16");
    scan(1'b0, 20, 10, 0, -1, 1, 20, "R6 early stop");
    scan(1'b0, 3, 4, 1, -1, 0, 7, "R10 gaps");
    scan(1'b0, 2, 2, 0, 100, 0, 4, "R8 mid start");
    quick(8'h00, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule